// File: doc/BRIEF.md
# Standby Memory Write-Lock Controller

This block holds a single 32-bit control register that guards a small standby SRAM with one lock flag. Out of reset the memory is locked. The flag opens only after three consecutive register writes that carry fixed patterns in a 3-bit unlock field, in a fixed order. A single write of a 4-bit key into a separate lock field closes it again. Each write is checked on both fields together. A write that mixes a non-zero key in one field with anything set in the other is rejected.

The lock flag comes out as a status output and is also used inside the block. While the memory is locked, the write enable of a separate memory port toward the SRAM is forced low. Address, data and read enable pass through unchanged. Software reads the flag at bit 0 of the register. The key fields always read back as zero.

Top module: `sbLockCtl`

## Requirements
- R1: After reset the register reads 0x00000000, the lock status output is 0 (locked), and memory writes are blocked.
- R2: Register bit 0 reads the lock flag, where 1 means unlocked. Bits [3:1] (unlock field) and [7:4] (lock field) always read as zero, and bits [31:8] read as zero.
- R3: Three consecutive register writes with unlock field 3'b001, then 3'b011, then 3'b111, each with lock field 4'b0000, set the flag to 1. The flag changes on the clock edge of the third write, so a read in the next cycle returns 1.
- R4: Writing the patterns in any other order does not unlock. Any register write that does not continue the sequence returns the tracker to idle. A valid 3'b001 write starts the sequence again at step one.
- R5: A write with a non-zero unlock field and any lock-field bit set is invalid. It does not advance the sequence, it resets the tracker, and it does not unlock.
- R6: A write with lock field 4'b1001 and unlock field 3'b000 clears the flag to 0 on its clock edge. It also discards any partial unlock progress.
- R7: A write with lock field 4'b1001 and any unlock-field bit set does not lock.
- R8: Register reads and writes to other addresses neither advance nor break the unlock sequence.
- R9: Completing the unlock sequence while already unlocked leaves the flag at 1.
- R10: While locked, the memory write enable output is 0. While unlocked, it follows the input. The memory read enable, address and data always pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register bus address |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational, valid when regAddr selects the register |
| unlocked | output | 1 | Lock flag, 1 means unlocked |
| memWeIn | input | 1 | Memory port write enable from the requester |
| memReIn | input | 1 | Memory port read enable from the requester |
| memAddrIn | input | MEM_AW | Memory port address |
| memWdataIn | input | MEM_DW | Memory port write data |
| memWeOut | output | 1 | Gated write enable to the SRAM |
| memReOut | output | 1 | Read enable to the SRAM |
| memAddrOut | output | MEM_AW | Address to the SRAM |
| memWdataOut | output | MEM_DW | Write data to the SRAM |

## Verification
Several properties are checked on every cycle:
- the gating of memory writes by the flag;
- the zero read-back of both key fields and the upper bits;
- the flag holding when no register write occurs;
- a valid lock write clearing the flag on the next cycle;
- a key write with a polluted unlock field never clearing the flag.

Other behaviour depends on the history of several writes, and only the bench's directed scenarios can show it:
- the ordered three-write unlock;
- the reset of the tracker after a wrong or invalid write;
- the restart on a repeated first pattern;
- the sequence surviving reads and foreign-address writes.

// File: rtl/sbLockPkg.sv
package sbLockPkg;
  localparam int REG_W = 32;
  localparam int ULK_LSB = 1;
  localparam int ULK_W = 3;
  localparam int LCK_LSB = 4;
  localparam int LCK_W = 4;

  localparam logic [ULK_W-1:0] ULK_STEP1 = 3'b001;
  localparam logic [ULK_W-1:0] ULK_STEP2 = 3'b011;
  localparam logic [ULK_W-1:0] ULK_STEP3 = 3'b111;
  localparam logic [LCK_W-1:0] LCK_KEY = 4'b1001;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_STEP1 = 2'd1,
    SEQ_STEP2 = 2'd2
  } seqState_t;

  typedef struct packed {
    logic setUnlock;
    logic setLock;
  } flagCmd_t;
endpackage

// File: rtl/sbLockCtrl.sv
module sbLockCtrl
  import sbLockPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrHit,
  input  logic [ULK_W-1:0] ulkField,
  input  logic [LCK_W-1:0] lckField,
  output flagCmd_t         cmd
);
  seqState_t seqQ, seqD;
  logic lckZero, ulkZero;
  logic lockValid;

  assign lckZero   = (lckField == '0);
  assign ulkZero   = (ulkField == '0);
  assign lockValid = wrHit && (lckField == LCK_KEY) && ulkZero;

  always_comb begin
    seqD = seqQ;
    cmd  = '0;
    if (wrHit) begin
      seqD = SEQ_IDLE;
      if (lockValid) begin
        cmd.setLock = 1'b1;
      end else if (lckZero) begin
        unique case (seqQ)
          SEQ_STEP1: begin
            if (ulkField == ULK_STEP2) seqD = SEQ_STEP2;
            else if (ulkField == ULK_STEP1) seqD = SEQ_STEP1;
          end
          SEQ_STEP2: begin
            if (ulkField == ULK_STEP3) cmd.setUnlock = 1'b1;
            else if (ulkField == ULK_STEP1) seqD = SEQ_STEP1;
          end
          default: begin
            if (ulkField == ULK_STEP1) seqD = SEQ_STEP1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seqQ <= SEQ_IDLE;
    else       seqQ <= seqD;
  end
endmodule

// File: rtl/sbLockData.sv
module sbLockData
  import sbLockPkg::*;
#(
  parameter int MEM_AW = 8,
  parameter int MEM_DW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagCmd_t          cmd,
  output logic              flagQ,
  output logic [REG_W-1:0]  rdView,
  input  logic              memWeIn,
  input  logic              memReIn,
  input  logic [MEM_AW-1:0] memAddrIn,
  input  logic [MEM_DW-1:0] memWdataIn,
  output logic              memWeOut,
  output logic              memReOut,
  output logic [MEM_AW-1:0] memAddrOut,
  output logic [MEM_DW-1:0] memWdataOut
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              flagQ <= 1'b0;
    else if (cmd.setLock)   flagQ <= 1'b0;
    else if (cmd.setUnlock) flagQ <= 1'b1;
  end

  assign rdView      = {{(REG_W-1){1'b0}}, flagQ};
  assign memWeOut    = memWeIn & flagQ;
  assign memReOut    = memReIn;
  assign memAddrOut  = memAddrIn;
  assign memWdataOut = memWdataIn;
endmodule

// File: rtl/sbLockCtl.sv
module sbLockCtl
  import sbLockPkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hE0,
  parameter int MEM_AW   = 8,
  parameter int MEM_DW   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic              unlocked,
  input  logic              memWeIn,
  input  logic              memReIn,
  input  logic [MEM_AW-1:0] memAddrIn,
  input  logic [MEM_DW-1:0] memWdataIn,
  output logic              memWeOut,
  output logic              memReOut,
  output logic [MEM_AW-1:0] memAddrOut,
  output logic [MEM_DW-1:0] memWdataOut
);
  logic sel, wrHit;
  flagCmd_t cmd;
  logic [REG_W-1:0] rdView;
  logic flagQ;

  assign sel   = (regAddr == REG_ADDR);
  assign wrHit = sel && regWe;

  sbLockCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrHit    (wrHit),
    .ulkField (regWdata[ULK_LSB +: ULK_W]),
    .lckField (regWdata[LCK_LSB +: LCK_W]),
    .cmd      (cmd)
  );

  sbLockData #(.MEM_AW(MEM_AW), .MEM_DW(MEM_DW)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .flagQ       (flagQ),
    .rdView      (rdView),
    .memWeIn     (memWeIn),
    .memReIn     (memReIn),
    .memAddrIn   (memAddrIn),
    .memWdataIn  (memWdataIn),
    .memWeOut    (memWeOut),
    .memReOut    (memReOut),
    .memAddrOut  (memAddrOut),
    .memWdataOut (memWdataOut)
  );

  assign regRdata = (sel && regRe) ? rdView : '0;
  assign unlocked = flagQ;
endmodule

// File: rtl/sbLockCtlChk.sv
module sbLockCtlChk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hE0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic [31:0]       regWdata,
  input logic [31:0]       regRdata,
  input logic              unlocked,
  input logic              memWeIn,
  input logic              memWeOut
);
  logic hit;
  assign hit = regWe && (regAddr == REG_ADDR);

  a_r10_we_gated: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |-> !memWeOut);
  a_r10_we_pass: assert property (@(posedge clk) disable iff (!rstN)
    unlocked |-> (memWeOut == memWeIn));
  a_r2_fields_zero: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[31:1] == '0);
  a_r8_hold_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !hit |=> $stable(unlocked));
  a_r6_lock_clears: assert property (@(posedge clk) disable iff (!rstN)
    (hit && regWdata[7:4] == 4'b1001 && regWdata[3:1] == 3'b000) |=> !unlocked);
  a_r7_bad_lock_no_clear: assert property (@(posedge clk) disable iff (!rstN)
    (hit && unlocked && regWdata[7:4] == 4'b1001 && regWdata[3:1] != 3'b000) |=> unlocked);
endmodule

bind sbLockCtl sbLockCtlChk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) uChk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
  .regRdata(regRdata), .unlocked(unlocked), .memWeIn(memWeIn), .memWeOut(memWeOut)
);

// File: tb/tb_sbLockCtl.sv
module tb_sbLockCtl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] regAddr = '0;
  logic regWe = 1'b0, regRe = 1'b0;
  logic [31:0] regWdata = '0, regRdata;
  logic unlocked;
  logic memWeIn = 1'b0, memReIn = 1'b0;
  logic [7:0] memAddrIn = '0, memAddrOut;
  logic [31:0] memWdataIn = '0, memWdataOut;
  logic memWeOut, memReOut;
  int nRun = 0, nFail = 0;

  localparam logic [7:0] RA = 8'hE0;

  always #10 clk = ~clk;

  sbLockCtl dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] u, input logic [3:0] l);
    @(negedge clk);
    regAddr = a; regWe = 1'b1; regWdata = {24'hABCDE0 & 24'h0, l, u, 1'b0};
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rdChk(input string req, input logic [31:0] exp);
    @(negedge clk);
    regAddr = RA; regRe = 1'b1;
    #1 chk(req, regRdata, exp);
    chk(req, {31'd0, unlocked}, exp);
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic doUnlock();
    wr(RA, 3'b001, 4'h0); wr(RA, 3'b011, 4'h0); wr(RA, 3'b111, 4'h0);
  endtask

  task automatic doLock();
    wr(RA, 3'b000, 4'b1001);
  endtask

  task automatic tReset();
    rdChk("R1", 32'h0);
    @(negedge clk); memWeIn = 1'b1; memReIn = 1'b1; memAddrIn = 8'h5A; memWdataIn = 32'h1234;
    #1 chk("R1", {31'd0, memWeOut}, 32'd0);
    chk("R10", {memReOut, memAddrOut, memWdataOut[15:0]}, {1'b1, 8'h5A, 16'h1234});
    memWeIn = 1'b0; memReIn = 1'b0;
  endtask

  task automatic tUnlock();
    wr(RA, 3'b001, 4'h0); wr(RA, 3'b011, 4'h0);
    @(negedge clk); regAddr = RA; regWe = 1'b1; regWdata = 32'h0000_000E;
    @(posedge clk); #1 chk("R3", {31'd0, unlocked}, 32'd1);
    @(negedge clk); regWe = 1'b0;
    rdChk("R3", 32'h1);
    @(negedge clk); memWeIn = 1'b1; #1 chk("R10", {31'd0, memWeOut}, 32'd1);
    memWeIn = 1'b0;
    @(negedge clk); regAddr = RA; regRe = 1'b1; regWe = 1'b1; regWdata = 32'hFFFF_FF0E;
    #1 chk("R2", regRdata, 32'h1);
    @(negedge clk); regWe = 1'b0; regRe = 1'b0;
    doLock(); rdChk("R6", 32'h0);
    @(negedge clk); memWeIn = 1'b1; #1 chk("R10", {31'd0, memWeOut}, 32'd0);
    memWeIn = 1'b0;
  endtask

  task automatic tOrder();
    wr(RA, 3'b011, 0); wr(RA, 3'b001, 0); wr(RA, 3'b111, 0); rdChk("R4", 0);
    wr(RA, 3'b001, 0); wr(RA, 3'b111, 0); wr(RA, 3'b011, 0); wr(RA, 3'b111, 0); rdChk("R4", 0);
    wr(RA, 3'b001, 0); wr(RA, 3'b011, 0); wr(RA, 3'b000, 0); wr(RA, 3'b111, 0); rdChk("R4", 0);
    wr(RA, 3'b001, 0); wr(RA, 3'b001, 0); wr(RA, 3'b011, 0); wr(RA, 3'b111, 0); rdChk("R4", 1);
    doLock();
    wr(RA, 3'b001, 0); wr(RA, 3'b011, 0); wr(RA, 3'b001, 0); wr(RA, 3'b011, 0); wr(RA, 3'b111, 0);
    rdChk("R4", 1);
    doLock();
  endtask

  task automatic tInvalid();
    wr(RA, 3'b001, 4'h2); wr(RA, 3'b011, 0); wr(RA, 3'b111, 0); rdChk("R5", 0);
    wr(RA, 3'b001, 0); wr(RA, 3'b011, 4'h8); wr(RA, 3'b111, 0); rdChk("R5", 0);
    wr(RA, 3'b001, 0); wr(RA, 3'b011, 0); wr(RA, 3'b111, 4'h1); rdChk("R5", 0);
    doUnlock(); wr(RA, 3'b001, 4'b1001); rdChk("R7", 1);
    wr(RA, 3'b100, 4'b1001); rdChk("R7", 1);
    doLock(); rdChk("R6", 0);
  endtask

  task automatic tPartialLock();
    wr(RA, 3'b001, 0); wr(RA, 3'b011, 0); doLock(); wr(RA, 3'b111, 0); rdChk("R6", 0);
  endtask

  task automatic tInterleave();
    wr(RA, 3'b001, 0);
    rdChk("R8", 0);
    wr(8'h10, 3'b000, 4'h0);
    wr(RA, 3'b011, 0);
    wr(8'hE4, 3'b101, 4'hF);
    rdChk("R8", 0);
    wr(RA, 3'b111, 0);
    rdChk("R8", 1);
    wr(8'h20, 3'b000, 4'b1001);
    rdChk("R8", 1);
  endtask

  task automatic tRelock();
    doUnlock(); rdChk("R9", 1);
    doLock();
  endtask

  initial begin
    #2000000;
    nFail++; nRun++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tUnlock();
    tOrder();
    tInvalid();
    tPartialLock();
    tInterleave();
    tRelock();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule